// File: doc/BRIEF.md
# Phase-Stepped SD Card Clock Generator

This block derives three related clocks for an SD host from one fast source: a transmit clock that paces the host controller, a card clock that leaves through the pads, and a receive clock that samples returning data. The fast source is not a real clock here. It arrives as a train of single-cycle enable pulses, one per phase step, so every flop in the block runs on the system clock. One card-clock period is cut into a whole number of phase steps. The transmit clock rises on step zero. The card clock and the receive clock each trail it by their own programmable number of steps.

Software sets the block up through a small register port. The fields cover the step resolution, the choice of source, the divide ratio and generator mode, the two delays, two clock enables and a soft reset. A read-only status word tells software which clocks are running. A new ratio, mode or delay never takes effect part-way through a period. It is held in a shadow copy and loaded when the phase counter wraps. While the generator is idle the shadow copy loads at once.

Top module: `sdclk_gen`

## Requirements
- R1: MODE (address 0) bits [2:0] select the steps per cycle N: code 0 gives 20, 1 gives 10, 2 gives 16, 3 gives 8, 4 gives 12, 5 gives 6, 6 gives 5 and 7 gives 4. With divided mode and a ratio field of 0, the transmit clock period is N steps.
- R2: MODE bits [5:4] select the step source: 0 stops the generator with all three clocks low, 1 takes steps from altTick, and 2 or 3 take steps from vcoTick.
- R3: DELAY (address 2) bits [4:0] set the card-clock lag behind the transmit clock in steps (reset value 5). Bits [12:8] set the receive-clock lag (reset value 6). A lag of 0 makes the clock rise together with the transmit clock.
- R4: A lag equal to or larger than the period P is treated as P-1 steps.
- R5: With MODE bit 8 set (divided mode), the period is P = N*(F+1) steps, where F is FREQ (address 1) bits [9:0]. Every clock is high for floor(P/2) steps of each period.
- R6: With MODE bit 8 clear (programmable mode), the period is F+1 steps, but never less than 2.
- R7: ENABLE (address 3) bit 0 runs the transmit and receive clocks. Bit 1 passes the card clock out. With bit 1 clear the card clock stays low and the transmit clock keeps running.
- R8: CTRL (address 4) bit 0 is the soft reset. It resets to 1, and while it is set all three clocks are low. All registers read back their reset values: MODE 0, FREQ 0, DELAY 0x0605, ENABLE 0, CTRL 0x0001.
- R9: CTRL bits 8, 9 and 10 report that the transmit, card and receive clocks are running. Bit 11 is set only when all three are set. Writes to these bits are ignored.
- R10: A change of ratio, mode or delay written mid-period leaves the current period at its old length. The new values apply from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| vcoTick | input | 1 | Step enable from the main source |
| altTick | input | 1 | Step enable from the alternate source |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for reads and writes |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Register read data for regAddr |
| txClk | output | 1 | Transmit clock to the host controller |
| cardClk | output | 1 | Clock driven to the card |
| rxClk | output | 1 | Receive sampling clock |

## Verification
The properties assume that the tick inputs are one-cycle enables sampled at the rising edge. They also assume that a register write lasts exactly one cycle and that the read address is held steady for the cycle in which the soft-reset bit is observed. The bench changes every input on the falling edge. It pulses altTick every other cycle and holds vcoTick high, so the step spacing is known. It lets each new setting settle for at least two old and two new periods before it measures, so the shadow load at the wrap has already happened.

// File: rtl/sdclk_pkg.sv
`timescale 1ns/1ps
package sdclk_pkg;
  parameter int FREQ_W = 10;
  parameter int DLY_W = 5;
  parameter int CODE_W = 3;
  parameter int STEP_W = 5;
  parameter int PHASE_W = FREQ_W + 6;
  parameter int NUM_TAPS = 3;

  localparam logic [2:0] ADDR_MODE = 3'd0;
  localparam logic [2:0] ADDR_FREQ = 3'd1;
  localparam logic [2:0] ADDR_DELAY = 3'd2;
  localparam logic [2:0] ADDR_ENABLE = 3'd3;
  localparam logic [2:0] ADDR_CTRL = 3'd4;

  typedef struct packed {
    logic [CODE_W-1:0] stepCode;
    logic [1:0]        srcSel;
    logic              divMode;
    logic [FREQ_W-1:0] freqSel;
    logic [DLY_W-1:0]  cardDly;
    logic [DLY_W-1:0]  rxDly;
  } clkCfg_t;

  typedef struct packed {
    logic tick;
    logic idle;
    logic runTx;
    logic cardOn;
  } genStrobe_t;

  function automatic logic [STEP_W-1:0] stepsForCode(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    stepsForCode = 5'd20;
      3'd1:    stepsForCode = 5'd10;
      3'd2:    stepsForCode = 5'd16;
      3'd3:    stepsForCode = 5'd8;
      3'd4:    stepsForCode = 5'd12;
      3'd5:    stepsForCode = 5'd6;
      3'd6:    stepsForCode = 5'd5;
      default: stepsForCode = 5'd4;
    endcase
  endfunction
endpackage

// File: rtl/sdclk_regs.sv
`timescale 1ns/1ps
module sdclk_regs
  import sdclk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vcoTick,
  input  logic              altTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output clkCfg_t           cfg,
  output genStrobe_t        strb
);
  localparam logic [DLY_W-1:0] CARD_DLY_RST = DLY_W'(5);
  localparam logic [DLY_W-1:0] RX_DLY_RST = DLY_W'(6);

  clkCfg_t cfgR;
  logic txEnR, cardOnR, holdR;
  logic running, txRun, cardRun, rxRun, allReady;
  logic unusedWr;

  assign unusedWr = ^wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgR.stepCode <= '0;
      cfgR.srcSel <= '0;
      cfgR.divMode <= 1'b0;
      cfgR.freqSel <= '0;
      cfgR.cardDly <= CARD_DLY_RST;
      cfgR.rxDly <= RX_DLY_RST;
      txEnR <= 1'b0;
      cardOnR <= 1'b0;
      holdR <= 1'b1;
    end else if (wrEn) begin
      case (regAddr)
        ADDR_MODE: begin
          cfgR.stepCode <= wrData[CODE_W-1:0];
          cfgR.srcSel <= wrData[5:4];
          cfgR.divMode <= wrData[8];
        end
        ADDR_FREQ: cfgR.freqSel <= wrData[FREQ_W-1:0];
        ADDR_DELAY: begin
          cfgR.cardDly <= wrData[DLY_W-1:0];
          cfgR.rxDly <= wrData[8+DLY_W-1:8];
        end
        ADDR_ENABLE: begin
          txEnR <= wrData[0];
          cardOnR <= wrData[1];
        end
        ADDR_CTRL: holdR <= wrData[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    running = !holdR && (cfgR.srcSel != 2'd0) && txEnR;
    txRun = running;
    cardRun = running && cardOnR;
    rxRun = running;
    allReady = txRun && cardRun && rxRun;
  end

  always_comb begin
    strb.tick = (cfgR.srcSel == 2'd1) ? altTick : (cfgR.srcSel[1] && vcoTick);
    strb.idle = !running;
    strb.runTx = running;
    strb.cardOn = cardOnR;
  end

  assign cfg = cfgR;

  always_comb begin
    rdData = '0;
    case (regAddr)
      ADDR_MODE: begin
        rdData[CODE_W-1:0] = cfgR.stepCode;
        rdData[5:4] = cfgR.srcSel;
        rdData[8] = cfgR.divMode;
      end
      ADDR_FREQ: rdData[FREQ_W-1:0] = cfgR.freqSel;
      ADDR_DELAY: begin
        rdData[DLY_W-1:0] = cfgR.cardDly;
        rdData[8+DLY_W-1:8] = cfgR.rxDly;
      end
      ADDR_ENABLE: rdData[1:0] = {cardOnR, txEnR};
      ADDR_CTRL: begin
        rdData[0] = holdR;
        rdData[11:8] = {allReady, rxRun, cardRun, txRun};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdclk_tap.sv
`timescale 1ns/1ps
module sdclk_tap #(
  parameter int PHASE_W = 16,
  parameter int DLY_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PHASE_W-1:0] phase,
  input  logic [PHASE_W-1:0] period,
  input  logic [PHASE_W-1:0] half,
  input  logic [DLY_W-1:0]   dly,
  input  logic               en,
  output logic               tapClk
);
  logic [PHASE_W-1:0] dEff, shifted;

  always_comb begin
    dEff = (PHASE_W'(dly) >= period) ? period - 1'b1 : PHASE_W'(dly);
    shifted = (phase >= dEff) ? phase - dEff : phase + period - dEff;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tapClk <= 1'b0;
    else tapClk <= en && (shifted < half);
  end
endmodule

// File: rtl/sdclk_phase.sv
`timescale 1ns/1ps
module sdclk_phase
  import sdclk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  clkCfg_t    cfgIn,
  input  genStrobe_t strb,
  output logic       txClk,
  output logic       cardClk,
  output logic       rxClk
);
  clkCfg_t act;
  logic [PHASE_W-1:0] ph, period, half, freqPlus;
  logic [DLY_W-1:0] tapDly [NUM_TAPS];
  logic tapEn [NUM_TAPS];
  logic tapOut [NUM_TAPS];
  logic unusedSrc;

  assign unusedSrc = ^act.srcSel;

  always_comb begin
    freqPlus = PHASE_W'(act.freqSel) + 1'b1;
    if (act.divMode) period = PHASE_W'(stepsForCode(act.stepCode)) * freqPlus;
    else period = (freqPlus < PHASE_W'(2)) ? PHASE_W'(2) : freqPlus;
    half = period >> 1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ph <= '0;
      act <= '0;
    end else if (strb.idle) begin
      ph <= '0;
      act <= cfgIn;
    end else if (strb.tick) begin
      if (ph >= period - 1'b1) begin
        ph <= '0;
        act <= cfgIn;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  always_comb begin
    tapDly[0] = '0;
    tapDly[1] = act.cardDly;
    tapDly[2] = act.rxDly;
    tapEn[0] = strb.runTx;
    tapEn[1] = strb.runTx && strb.cardOn;
    tapEn[2] = strb.runTx;
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    sdclk_tap #(.PHASE_W(PHASE_W), .DLY_W(DLY_W)) u_tap (
      .clk(clk), .rstN(rstN), .phase(ph), .period(period), .half(half),
      .dly(tapDly[g]), .en(tapEn[g]), .tapClk(tapOut[g])
    );
  end

  assign txClk = tapOut[0];
  assign cardClk = tapOut[1];
  assign rxClk = tapOut[2];
endmodule

// File: rtl/sdclk_gen.sv
`timescale 1ns/1ps
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vcoTick,
  input  logic              altTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              txClk,
  output logic              cardClk,
  output logic              rxClk
);
  clkCfg_t cfg;
  genStrobe_t strb;

  sdclk_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .vcoTick(vcoTick), .altTick(altTick),
    .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData), .rdData(rdData),
    .cfg(cfg), .strb(strb)
  );

  sdclk_phase u_phase (
    .clk(clk), .rstN(rstN), .cfgIn(cfg), .strb(strb),
    .txClk(txClk), .cardClk(cardClk), .rxClk(rxClk)
  );
endmodule

// File: rtl/sdclk_chk.sv
`timescale 1ns/1ps
module sdclk_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        srcSel,
  input logic              runTx,
  input logic              cardOn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              rdBit0,
  input logic              txClk,
  input logic              cardClk,
  input logic              rxClk
);
  // R8
  soft_reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(4) && rdBit0) |=> (!txClk && !cardClk && !rxClk));

  // R2
  stopped_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'd0) |=> (!txClk && !cardClk && !rxClk));

  // R7
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runTx |=> (!txClk && !rxClk));

  // R7
  card_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cardOn |=> !cardClk);
endmodule

bind sdclk_gen sdclk_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .srcSel(cfg.srcSel), .runTx(strb.runTx),
  .cardOn(strb.cardOn), .regAddr(regAddr), .rdBit0(rdData[0]),
  .txClk(txClk), .cardClk(cardClk), .rxClk(rxClk)
);

// File: tb/test_sdclk_gen.sv
`timescale 1ns/1ps
module test_sdclk_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vcoTick = 1'b1;
  logic altTick = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic txClk, cardClk, rxClk;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    int period;
    int high;
    int cdel;
    int rdel;
    bit cardOn;
    string tag;
  } shape_t;
  shape_t expQ[$];

  int cyc = 0;
  int txRiseT = 0, prevTxRiseT = 0, txFallT = 0, cardRiseT = -1, rxRiseT = -1;
  int txRiseCnt = 0;
  logic txPrev = 0, cardPrev = 0, rxPrev = 0;
  int curP = 4;

  sdclk_gen i_sdclk_gen (
    .clk(clk), .rstN(rstN), .vcoTick(vcoTick), .altTick(altTick),
    .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData), .rdData(rdData),
    .txClk(txClk), .cardClk(cardClk), .rxClk(rxClk)
  );

  always #5 clk = ~clk;

  initial forever begin
    @(negedge clk);
    altTick = ~altTick;
  end

  // edge tracker sampled on the falling edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (cardClk && !cardPrev) cardRiseT = cyc;
    if (rxClk && !rxPrev) rxRiseT = cyc;
    if (!txClk && txPrev) txFallT = cyc;
    if (txClk && !txPrev) begin
      prevTxRiseT = txRiseT;
      txRiseT = cyc;
      txRiseCnt = txRiseCnt + 1;
    end
    txPrev = txClk;
    cardPrev = cardClk;
    rxPrev = rxClk;
  end

  task automatic check(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int nSteps(int code);
    case (code)
      0: return 20; 1: return 10; 2: return 16; 3: return 8;
      4: return 12; 5: return 6; 6: return 5; default: return 4;
    endcase
  endfunction

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    regAddr = a;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd_check(string req, logic [2:0] a, int exp);
    @(negedge clk);
    regAddr = a;
    #1;
    check(req, $sformatf("read addr %0d", a), int'(rdData), exp);
  endtask

  // configure, settle, then hand the expected shape to the monitor
  task automatic program_shape(string tag, int code, int f, bit divm, int src,
                               int cd, int rdl, bit cardOn);
    int p, sp, newP;
    wr(3'd0, 16'(code | (src << 4) | (int'(divm) << 8)));
    wr(3'd1, 16'(f));
    wr(3'd2, 16'(cd | (rdl << 8)));
    wr(3'd3, cardOn ? 16'd3 : 16'd1);
    sp = (src == 1) ? 2 : 1;
    p = divm ? nSteps(code) * (f + 1) : ((f + 1 < 2) ? 2 : f + 1);
    newP = p * sp;
    wait_cycles(2 * (curP + newP) + 8);
    curP = newP;
    expQ.push_back('{period: newP, high: (p / 2) * sp,
                     cdel: ((cd >= p) ? p - 1 : cd) * sp,
                     rdel: ((rdl >= p) ? p - 1 : rdl) * sp,
                     cardOn: cardOn, tag: tag});
    wait (expQ.size() == 0);
  endtask

  // monitor: pops expected shapes and compares them with measured edges
  initial forever begin
    shape_t it;
    int n0, per;
    wait (expQ.size() > 0);
    it = expQ[0];
    n0 = txRiseCnt;
    wait (txRiseCnt >= n0 + 2);
    per = txRiseT - prevTxRiseT;
    check(it.tag, "tx period", per, it.period);
    check(it.tag, "tx high time", txFallT - prevTxRiseT, it.high);
    check(it.tag, "rx lag", (rxRiseT - prevTxRiseT + per) % per, it.rdel);
    if (it.cardOn) check(it.tag, "card lag", (cardRiseT - prevTxRiseT + per) % per, it.cdel);
    else check(it.tag, "card silent", int'(cardRiseT >= prevTxRiseT), 0);
    void'(expQ.pop_front());
  end

  task automatic count_quiet(string req, int n);
    int c0;
    c0 = txRiseCnt;
    wait_cycles(n);
    check(req, "tx rises while quiet", txRiseCnt - c0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #3_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_cycles(3);
    rstN = 1'b1;
    // R8 reset values
    rd_check("R8", 3'd0, 0);
    rd_check("R8", 3'd1, 0);
    rd_check("R3", 3'd2, 16'h0605);
    rd_check("R8", 3'd3, 0);
    rd_check("R8", 3'd4, 16'h0001);
    check("R8", "tx after reset", int'(txClk), 0);

    // R8: configured but held in soft reset
    wr(3'd3, 16'd3);
    wr(3'd0, 16'h0127);
    count_quiet("R8", 40);
    check("R8", "card while held", int'(cardClk), 0);
    rd_check("R9", 3'd4, 16'h0001);

    // R9 status after release
    wr(3'd4, 16'h0000);
    rd_check("R9", 3'd4, 16'h0F00);

    // R3 defaults clamp at P=4 (R4)
    program_shape("R4", 7, 0, 1, 2, 5, 6, 1);
    program_shape("R3", 3, 0, 1, 2, 1, 2, 1);
    // R1 every step code
    for (int c = 0; c < 8; c++) program_shape("R1", c, 0, 1, 2, 1, 0, 1);
    // R5 odd period
    program_shape("R5", 6, 2, 1, 2, 5, 14, 1);
    program_shape("R4", 7, 1, 1, 2, 20, 31, 1);
    // R6 programmable mode and its minimum
    program_shape("R6", 0, 6, 0, 2, 2, 3, 1);
    program_shape("R6", 0, 0, 0, 2, 0, 4, 1);
    // R2 alternate source and code 3
    program_shape("R2", 7, 1, 1, 1, 3, 5, 1);
    program_shape("R2", 3, 0, 1, 3, 2, 4, 1);
    // R7 card gated, tx still runs
    program_shape("R7", 3, 0, 1, 2, 2, 4, 0);
    rd_check("R9", 3'd4, 16'h0500);
    wr(3'd4, 16'h0F00);
    rd_check("R9", 3'd4, 16'h0500);

    // R10 boundary load: period 20 then write ratio for 40 mid-period
    program_shape("R10", 0, 0, 1, 2, 1, 2, 1);
    begin
      int n0, t0, t1;
      n0 = txRiseCnt;
      wait (txRiseCnt == n0 + 1);
      t0 = txRiseT;
      wait_cycles(3);
      wr(3'd1, 16'd1);
      wait (txRiseCnt == n0 + 2);
      t1 = txRiseT;
      check("R10", "period during change", t1 - t0, 20);
      wait (txRiseCnt == n0 + 3);
      check("R10", "period after change", txRiseT - t1, 40);
    end

    // R2 stopped source
    wr(3'd0, 16'h0003);
    wait_cycles(3);
    count_quiet("R2", 60);
    check("R2", "rx while stopped", int'(rxClk), 0);

    // R7 transmit disabled with a live source
    wr(3'd0, 16'h0123);
    wr(3'd3, 16'd0);
    wait_cycles(3);
    count_quiet("R7", 60);

    finish_run();
  end
endmodule